// File: doc/BRIEF.md
# Instruction Address Match Trap

This block watches the fetch stage of a processor and raises a trap just before the processor executes an instruction that begins at one of four programmed addresses. Each of the four comparators holds a 24-bit address and has its own bit in a four-bit enable register. A simple write port loads one address register at a time, or the whole enable register.

The fetch stage presents the start address of every instruction it is about to execute, together with a strobe. The block compares only on cycles where that strobe is high. Data accesses, table reads and the later bytes of a multi-byte instruction are never presented with the strobe, so they can never trigger the trap.

The trap is non-maskable. The block has no mask input, and no interrupt-enable flag gates it. The request is registered and lasts one cycle for each matching instruction start. It comes with the index of the matching comparator, and the lowest index wins when several comparators match. Trap servicing and vectoring belong to the consumer of `trap_req`.

Top module: `addr_match_trap`

## Requirements
- R1: After reset, `trap_req` is 0 and `trap_idx` is 0, and every enable bit and address register is 0. As a result, a start strobe at address 0 traps only once an enable bit has been set.
- R2: When comparator i (i = 0..3) has enable bit i set and its address equals `fetch_start_addr` on a clock edge where `fetch_start_vld` is 1, `trap_req` is 1 and `trap_idx` is i in the cycle after that edge.
- R3: A comparator whose enable bit is 0 never causes a trap, whatever its address holds.
- R4: On a clock edge where `fetch_start_vld` is 0, no trap is produced in the next cycle, whatever `fetch_start_addr` holds. This covers data accesses, table reads and bytes inside an instruction.
- R5: When several enabled comparators match the same start, `trap_idx` reports the lowest matching index.
- R6: Each strobe cycle counts as a separate instruction start. `trap_req` is high for exactly the one cycle after each matching strobe edge. Consecutive matching strobes give consecutive high cycles, and the request drops in the cycle after a non-matching or absent strobe.
- R7: `trap_idx` is 0 whenever `trap_req` is 0.
- R8: A register write takes effect for strobes on the following clock edges. A strobe on the same edge as a write is compared against the old value.
- R9: All 24 address bits take part in the comparison. An address that differs from the programmed one only in bit 0 or only in bit 23 does not match.
- R10: A write to the enable register replaces all four bits at once. Bit i of `cfg_en_data` becomes the enable of comparator i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_addr_we | input | 1 | Write strobe for one comparator address register |
| cfg_addr_idx | input | 2 | Index of the address register to write |
| cfg_addr_data | input | 24 | New address value |
| cfg_en_we | input | 1 | Write strobe for the enable register |
| cfg_en_data | input | 4 | New enable bits, bit i for comparator i |
| fetch_start_vld | input | 1 | The fetch stage presents an instruction start address |
| fetch_start_addr | input | 24 | Start address of the next instruction |
| trap_req | output | 1 | One-cycle trap request |
| trap_idx | output | 2 | Matching comparator index, 0 when no request |

## Verification
A start strobe sampled at clock edge k produces its `trap_req` and `trap_idx` in the cycle that follows edge k. A register write sampled at edge k is first used by a strobe at edge k+1. The bench drives every input on the falling edge, which places each stimulus ahead of exactly one rising edge. It reads the outputs on the next falling edge, which is the one cycle where a result for that strobe is valid. The back-to-back, same-edge write and drop-out scenarios then sample one further falling edge, so the pulse width and the old-value comparison are checked cycle by cycle.

// File: rtl/addr_trap_pkg.sv
package addr_trap_pkg;
  localparam int unsigned DEF_ADDR_W  = 24;
  localparam int unsigned DEF_NUM_CMP = 4;
endpackage

// File: rtl/addr_trap_regs.sv
module addr_trap_regs #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned NUM_CMP = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_CMP)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            addr_we,
  input  logic [IDX_W-1:0]                addr_idx,
  input  logic [ADDR_W-1:0]               addr_data,
  input  logic                            en_we,
  input  logic [NUM_CMP-1:0]              en_data,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]  addr_q,
  output logic [NUM_CMP-1:0]              en_q
);
  logic [NUM_CMP-1:0][ADDR_W-1:0] addr_d;
  logic [NUM_CMP-1:0]             en_d;

  // next-state
  always_comb begin
    addr_d = addr_q;
    en_d   = en_q;
    if (addr_we) addr_d[addr_idx] = addr_data;
    if (en_we)   en_d = en_data;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= '0;
    end else begin
      if (addr_we) addr_q <= addr_d;
      if (en_we)   en_q   <= en_d;
    end
  end
endmodule

// File: rtl/addr_trap_cmp.sv
module addr_trap_cmp #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              enable,
  input  logic              probe_vld,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit
);
  always_comb hit = enable && probe_vld && (ref_addr == probe_addr);
endmodule

// File: rtl/addr_trap_prio.sv
module addr_trap_prio #(
  parameter int unsigned NUM_CMP = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_CMP)
) (
  input  logic [NUM_CMP-1:0] hits,
  output logic               any_hit,
  output logic [IDX_W-1:0]   low_idx
);
  // the scan runs downward so that the lowest index is written last and wins
  always_comb begin
    any_hit = |hits;
    low_idx = '0;
    for (int i = NUM_CMP - 1; i >= 0; i--) begin
      if (hits[i]) low_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/addr_match_trap.sv
module addr_match_trap
  import addr_trap_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned NUM_CMP = DEF_NUM_CMP,
  localparam int unsigned IDX_W  = $clog2(NUM_CMP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_addr_we,
  input  logic [IDX_W-1:0]   cfg_addr_idx,
  input  logic [ADDR_W-1:0]  cfg_addr_data,
  input  logic               cfg_en_we,
  input  logic [NUM_CMP-1:0] cfg_en_data,
  input  logic               fetch_start_vld,
  input  logic [ADDR_W-1:0]  fetch_start_addr,
  output logic               trap_req,
  output logic [IDX_W-1:0]   trap_idx
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_CMP-1:0]             en_q;
  logic [NUM_CMP-1:0]             hits;
  logic                           any_hit;
  logic [IDX_W-1:0]               low_idx;

  addr_trap_regs #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .addr_we   (cfg_addr_we),
    .addr_idx  (cfg_addr_idx),
    .addr_data (cfg_addr_data),
    .en_we     (cfg_en_we),
    .en_data   (cfg_en_data),
    .addr_q    (addr_q),
    .en_q      (en_q)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    addr_trap_cmp #(.ADDR_W(ADDR_W)) cmp_i (
      .enable     (en_q[g]),
      .probe_vld  (fetch_start_vld),
      .ref_addr   (addr_q[g]),
      .probe_addr (fetch_start_addr),
      .hit        (hits[g])
    );
  end

  addr_trap_prio #(.NUM_CMP(NUM_CMP)) prio_i (
    .hits    (hits),
    .any_hit (any_hit),
    .low_idx (low_idx)
  );

  logic             trap_req_d, trap_req_q;
  logic [IDX_W-1:0] trap_idx_d, trap_idx_q;

  // next-state
  always_comb begin
    trap_req_d = any_hit;
    trap_idx_d = any_hit ? low_idx : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      trap_req_q <= 1'b0;
      trap_idx_q <= '0;
    end else begin
      trap_req_q <= trap_req_d;
      trap_idx_q <= trap_idx_d;
    end
  end

  assign trap_req = trap_req_q;
  assign trap_idx = trap_idx_q;
endmodule

// File: rtl/addr_match_trap_chk.sv
module addr_match_trap_chk #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned NUM_CMP = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_CMP)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           fetch_start_vld,
  input logic [ADDR_W-1:0]              fetch_start_addr,
  input logic                           trap_req,
  input logic [IDX_W-1:0]               trap_idx,
  input logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q,
  input logic [NUM_CMP-1:0]             en_q
);
  // R4
  a_r4_no_strobe_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_start_vld |=> !trap_req);

  // R3
  a_r3_all_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !trap_req);

  // R2, R5: comparator 0 always wins when it matches
  a_r2_cmp0_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start_vld && en_q[0] && (addr_q[0] == fetch_start_addr))
      |=> (trap_req && (trap_idx == '0)));

  // R7
  a_r7_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_idx == '0));
endmodule

bind addr_match_trap addr_match_trap_chk #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .fetch_start_vld  (fetch_start_vld),
  .fetch_start_addr (fetch_start_addr),
  .trap_req         (trap_req),
  .trap_idx         (trap_idx),
  .addr_q           (addr_q),
  .en_q             (en_q)
);

// File: tb/addr_match_trap_tb_top.sv
`timescale 1ns/1ps
module addr_match_trap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_addr_we;
  logic [1:0]  cfg_addr_idx;
  logic [23:0] cfg_addr_data;
  logic        cfg_en_we;
  logic [3:0]  cfg_en_data;
  logic        fetch_start_vld;
  logic [23:0] fetch_start_addr;
  logic        trap_req;
  logic [1:0]  trap_idx;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  addr_match_trap dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_addr_we      (cfg_addr_we),
    .cfg_addr_idx     (cfg_addr_idx),
    .cfg_addr_data    (cfg_addr_data),
    .cfg_en_we        (cfg_en_we),
    .cfg_en_data      (cfg_en_data),
    .fetch_start_vld  (fetch_start_vld),
    .fetch_start_addr (fetch_start_addr),
    .trap_req         (trap_req),
    .trap_idx         (trap_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr_addr(input logic [1:0] idx, input logic [23:0] a);
    cfg_addr_we = 1'b1; cfg_addr_idx = idx; cfg_addr_data = a;
    @(negedge clk);
    cfg_addr_we = 1'b0;
  endtask

  task automatic wr_en(input logic [3:0] bits);
    cfg_en_we = 1'b1; cfg_en_data = bits;
    @(negedge clk);
    cfg_en_we = 1'b0;
  endtask

  task automatic probe(input logic v, input logic [23:0] a,
                       output logic req, output logic [1:0] idx);
    fetch_start_vld = v; fetch_start_addr = a;
    @(negedge clk);
    fetch_start_vld = 1'b0;
    req = trap_req; idx = trap_idx;
  endtask

  task automatic t_reset();
    logic r; logic [1:0] i;
    check("R1 trap_req after reset", 32'(trap_req), 0);
    check("R1 trap_idx after reset", 32'(trap_idx), 0);
    probe(1'b1, 24'h0, r, i);
    check("R1 no trap with enables cleared", 32'(r), 0);
    wr_en(4'b0001);
    probe(1'b1, 24'h0, r, i);
    check("R1 address reg 0 reset to zero", 32'(r), 1);
    wr_en(4'b0000);
  endtask

  task automatic t_single();
    logic r; logic [1:0] i;
    for (int k = 0; k < 4; k++) wr_addr(2'(k), 24'h100000 + 24'(k * 16));
    for (int k = 0; k < 4; k++) begin
      wr_en(4'(1 << k));
      probe(1'b1, 24'h100000 + 24'(k * 16), r, i);
      check($sformatf("R2 req comparator %0d", k), 32'(r), 1);
      check($sformatf("R2 idx comparator %0d", k), 32'(i), 32'(k));
    end
    wr_en(4'b0000);
  endtask

  task automatic t_disabled();
    logic r; logic [1:0] i;
    wr_en(4'b1011);
    probe(1'b1, 24'h100020, r, i);
    check("R3 disabled comparator 2 silent", 32'(r), 0);
    wr_en(4'b0000);
  endtask

  task automatic t_no_strobe();
    logic r; logic [1:0] i;
    wr_en(4'b1111);
    probe(1'b0, 24'h100010, r, i);
    check("R4 no strobe, matching address", 32'(r), 0);
    probe(1'b0, 24'h100000, r, i);
    check("R4 no strobe, idx stays 0", 32'(i), 0);
    wr_en(4'b0000);
  endtask

  task automatic t_priority();
    logic r; logic [1:0] i;
    for (int k = 1; k < 4; k++) wr_addr(2'(k), 24'h5A5A5A);
    wr_en(4'b1110);
    probe(1'b1, 24'h5A5A5A, r, i);
    check("R5 lowest of 1..3 req", 32'(r), 1);
    check("R5 lowest of 1..3 idx", 32'(i), 1);
    wr_addr(2'd0, 24'h5A5A5A);
    wr_en(4'b1111);
    probe(1'b1, 24'h5A5A5A, r, i);
    check("R5 all four match idx", 32'(i), 0);
    wr_en(4'b1000);
    probe(1'b1, 24'h5A5A5A, r, i);
    check("R5 only 3 enabled idx", 32'(i), 3);
    wr_en(4'b0000);
  endtask

  task automatic t_pulse();
    wr_addr(2'd2, 24'h00C0DE);
    wr_en(4'b0100);
    fetch_start_vld = 1'b1; fetch_start_addr = 24'h00C0DE;
    @(negedge clk);
    check("R6 first start high", 32'(trap_req), 1);
    @(negedge clk);
    check("R6 back-to-back start high", 32'(trap_req), 1);
    fetch_start_addr = 24'h00C0DF;
    @(negedge clk);
    check("R6 drops after non-matching start", 32'(trap_req), 0);
    fetch_start_vld = 1'b0;
    @(negedge clk);
    check("R6 stays low without start", 32'(trap_req), 0);
    check("R7 idx 0 after idx 2 trap", 32'(trap_idx), 0);
    wr_en(4'b0000);
  endtask

  task automatic t_write_timing();
    logic r; logic [1:0] i;
    wr_addr(2'd3, 24'h111111);
    wr_en(4'b1000);
    cfg_addr_we = 1'b1; cfg_addr_idx = 2'd3; cfg_addr_data = 24'h00ABCD;
    fetch_start_vld = 1'b1; fetch_start_addr = 24'h00ABCD;
    @(negedge clk);
    cfg_addr_we = 1'b0; fetch_start_vld = 1'b0;
    check("R8 same-edge strobe uses old value", 32'(trap_req), 0);
    probe(1'b1, 24'h00ABCD, r, i);
    check("R8 new value used next edge", 32'(r), 1);
    check("R8 new value idx", 32'(i), 3);
    cfg_en_we = 1'b1; cfg_en_data = 4'b0000;
    fetch_start_vld = 1'b1; fetch_start_addr = 24'h00ABCD;
    @(negedge clk);
    cfg_en_we = 1'b0; fetch_start_vld = 1'b0;
    check("R8 same-edge enable clear uses old enable", 32'(trap_req), 1);
  endtask

  task automatic t_width();
    logic r; logic [1:0] i;
    wr_addr(2'd1, 24'h3C00F2);
    wr_en(4'b0010);
    probe(1'b1, 24'h3C00F3, r, i);
    check("R9 bit 0 differs", 32'(r), 0);
    probe(1'b1, 24'hBC00F2, r, i);
    check("R9 bit 23 differs", 32'(r), 0);
    probe(1'b1, 24'h3C00F2, r, i);
    check("R9 exact match", 32'(r), 1);
    wr_en(4'b0000);
  endtask

  task automatic t_en_replace();
    logic r; logic [1:0] i;
    for (int k = 0; k < 4; k++) wr_addr(2'(k), 24'h777777);
    wr_en(4'b1111);
    wr_en(4'b0100);
    probe(1'b1, 24'h777777, r, i);
    check("R10 enable replaced req", 32'(r), 1);
    check("R10 enable replaced idx", 32'(i), 2);
    wr_en(4'b0000);
  endtask

  logic done = 1'b0;

  initial begin
    rst_n = 1'b0;
    cfg_addr_we = 1'b0; cfg_addr_idx = '0; cfg_addr_data = '0;
    cfg_en_we = 1'b0; cfg_en_data = '0;
    fetch_start_vld = 1'b0; fetch_start_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_disabled();
    t_no_strobe();
    t_priority();
    t_pulse();
    t_write_timing();
    t_width();
    t_en_replace();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule